// File: doc/BRIEF.md
# Digital Time-Delay-Integration Summer with Serial Output

This block sits behind the in-pixel converters of a scanning line sensor. Every stage of a TDI row delivers a digitized sample word, and all stages present their words together under one valid strobe. A scene point moves past the stages one after another, so its contributions are spread across time. The block lines them up with a chain of partial sums. The spacing between stages is a programmable number of valid strobes, the oversampling ratio of 2 or 3. The scan direction decides which physical stage a scene point meets first.

Any stage can be excluded from the sum. The finished sum is divided by the number of stages still included, rounded to 16 bits, and sent out one bit per clock. Two paths load the configuration. The parallel path sets only the oversampling ratio. The serial path sets the ratio and the stage-enable mask together.

A small state machine runs the output side. ST_IDLE goes to ST_DIV when a completed sum arrives. ST_DIV goes to ST_SHIFT after one cycle for each bit of the 19-bit sum. ST_SHIFT goes back to ST_IDLE after 16 bits. Valid strobes must be at least 36 clocks apart. A sum that completes while the machine is not in ST_IDLE is not sent.

Top module: `tdi_serial_sum`

## Requirements
- R1: During reset and afterwards, `ser_out` and `frame_strobe` are 0 until a word is sent. Reset selects an oversampling ratio of 2 and enables all eight stages.
- R2: With scan_dir=0, a word is produced at each accepted valid once the chain is full. Logical stage k is physical stage k. With D=7×ratio, the word sums logical stage k's sample from the valid D−k×ratio strobes earlier (k=0..7), where k=7 is the current valid.
- R3: A pulse on `cfg_par_wr` loads the ratio from `cfg_par_osr3` (0 selects 2, 1 selects 3). The stage spacing in R2 then follows the new ratio.
- R4: With scan_dir=1, logical stage k is physical stage 7−k, so the order in which stages contribute is reversed.
- R5: A disabled stage adds zero to the sum. A parallel write never changes the enable mask.
- R6: The word equals floor((sum + floor(N/2)) / N), where N is the count of enabled stages. Full-scale input on all stages gives 0xFFFF with no overflow.
- R7: With no stage enabled, every produced word is 0x0000.
- R8: A word is sent MSB first, one bit per clock. Its first bit appears at the 19th clock edge after the valid that completed the sum. `frame_strobe` is high only with that first bit, and both outputs are 0 between words.
- R9: After reset, after any configuration load, or after a change of scan_dir, no word is sent until D+1 valids have been accepted. The first word comes with the (D+1)th valid.
- R10: Serial configuration takes 9 bits shifted in on `cfg_ser_bit` while `cfg_ser_shift` is high. The first bit is the ratio select, then mask bits for stages 7 down to 0. A `cfg_ser_latch` pulse applies all of them; mask bit s enables physical stage s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | All stage samples are present this cycle |
| smp_data | input | 128 | Stage s sample at bits [16s+15:16s] |
| scan_dir | input | 1 | 0 forward, 1 reverse scan |
| cfg_par_wr | input | 1 | Parallel configuration write strobe |
| cfg_par_osr3 | input | 1 | Ratio select for parallel write |
| cfg_ser_shift | input | 1 | Shift one serial configuration bit |
| cfg_ser_bit | input | 1 | Serial configuration data |
| cfg_ser_latch | input | 1 | Apply shifted serial configuration |
| ser_out | output | 1 | Serial result bit |
| frame_strobe | output | 1 | Marks the first bit of each word |

## Verification
The bench drives pseudo-random and full-scale samples under both ratios and both scan directions. It targets the cases that break in the stage alignment. A swapped stage index or a wrong ratio spacing produces wrong sums. A missed warm-up clear releases words built from stale partial sums. It also exercises masks with an odd count of enabled stages, which catch a divider that truncates instead of rounding. A single-stage mask and an empty mask show up a wrong divisor or a garbage quotient for N=0. Every clock is compared, so a word that comes one cycle late, leaves out its frame strobe or lets bits through while idle is reported at once.

// File: rtl/tdi_pkg.sv
`timescale 1ns/1ps
package tdi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIV   = 2'd1,
        ST_SHIFT = 2'd2
    } ser_state_e;
endpackage

// File: rtl/tdi_cfg_regs.sv
`timescale 1ns/1ps
module tdi_cfg_regs #(
    parameter int NSTAGE = 8,
    localparam int CW = $clog2(NSTAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_wr,
    input  logic              par_osr3,
    input  logic              ser_shift,
    input  logic              ser_bit,
    input  logic              ser_latch,
    output logic              osr3,
    output logic [NSTAGE-1:0] mask,
    output logic [CW-1:0]     n_active,
    output logic              cfg_apply
);
    logic [NSTAGE:0] shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            osr3   <= 1'b0;
            mask   <= '1;
        end else begin
            if (ser_shift)
                shadow <= {shadow[NSTAGE-1:0], ser_bit};
            if (par_wr)
                osr3 <= par_osr3;
            if (ser_latch) begin
                osr3 <= shadow[NSTAGE];
                mask <= shadow[NSTAGE-1:0];
            end
        end
    end

    assign cfg_apply = par_wr | ser_latch;

    always_comb begin
        n_active = '0;
        for (int i = 0; i < NSTAGE; i++)
            n_active = n_active + CW'(mask[i]);
    end
endmodule

// File: rtl/tdi_accum_chain.sv
`timescale 1ns/1ps
module tdi_accum_chain #(
    parameter int NSTAGE = 8,
    parameter int SAMP_W = 16,
    localparam int ACC_W  = SAMP_W + $clog2(NSTAGE),
    localparam int D_LO   = (NSTAGE - 1) * 2,
    localparam int D_HI   = (NSTAGE - 1) * 3,
    localparam int CHAIN  = D_HI,
    localparam int WARM_W = $clog2(CHAIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic [NSTAGE*SAMP_W-1:0] samples,
    input  logic                     scan_dir,
    input  logic                     osr3,
    input  logic [NSTAGE-1:0]        mask,
    input  logic                     clear,
    output logic                     done,
    output logic [ACC_W-1:0]         done_sum
);
    logic [SAMP_W-1:0] phys [NSTAGE];
    logic [SAMP_W-1:0] logi [NSTAGE];
    logic [ACC_W-1:0]  part_q [CHAIN];
    logic [ACC_W-1:0]  part_d [CHAIN];
    logic [WARM_W-1:0] warm_q;
    logic [WARM_W-1:0] depth;
    logic              dir_q;
    logic              dir_chg;
    logic [ACC_W-1:0]  last_part;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        assign phys[g] = mask[g] ? samples[g*SAMP_W +: SAMP_W] : '0;
        assign logi[g] = scan_dir ? phys[NSTAGE-1-g] : phys[g];
    end

    for (genvar j = 0; j < CHAIN; j++) begin : g_chain
        localparam bit HIT2 = ((j % 2) == 0) && ((j / 2) < NSTAGE);
        localparam bit HIT3 = ((j % 3) == 0) && ((j / 3) < NSTAGE);
        localparam int K2   = HIT2 ? (j / 2) : 0;
        localparam int K3   = HIT3 ? (j / 3) : 0;
        logic [SAMP_W-1:0] add2;
        logic [SAMP_W-1:0] add3;
        if (HIT2) begin : g_h2
            assign add2 = logi[K2];
        end else begin : g_n2
            assign add2 = '0;
        end
        if (HIT3) begin : g_h3
            assign add3 = logi[K3];
        end else begin : g_n3
            assign add3 = '0;
        end
        if (j == 0) begin : g_head
            assign part_d[j] = ACC_W'(osr3 ? add3 : add2);
        end else begin : g_body
            assign part_d[j] = part_q[j-1] + ACC_W'(osr3 ? add3 : add2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < CHAIN; j++)
                part_q[j] <= '0;
        end else if (valid) begin
            for (int j = 0; j < CHAIN; j++)
                part_q[j] <= part_d[j];
        end
    end

    assign dir_chg = scan_dir != dir_q;
    assign depth   = osr3 ? WARM_W'(D_HI) : WARM_W'(D_LO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            warm_q <= '0;
        end else begin
            dir_q <= scan_dir;
            if (clear || dir_chg)
                warm_q <= '0;
            else if (valid && warm_q < depth)
                warm_q <= warm_q + 1'b1;
        end
    end

    assign last_part = osr3 ? part_q[D_HI-1] : part_q[D_LO-1];
    assign done_sum  = last_part + ACC_W'(logi[NSTAGE-1]);
    assign done      = valid && (warm_q == depth) && !clear && !dir_chg;
endmodule

// File: rtl/tdi_norm_ser.sv
`timescale 1ns/1ps
module tdi_norm_ser
    import tdi_pkg::*;
#(
    parameter int ACC_W = 19,
    parameter int OUT_W = 16,
    parameter int CW    = 4,
    localparam int CNT_W = $clog2((ACC_W > OUT_W) ? ACC_W : OUT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ACC_W-1:0] sum,
    input  logic [CW-1:0]    n_act,
    output logic             ser_out,
    output logic             frame_strobe,
    output ser_state_e       fsm_state,
    output logic [CW-1:0]    n_held
);
    ser_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] dvd, dvd_nx;
    logic [CW-1:0]    rem, rem_nx;
    logic [CW:0]      trial, diff;
    logic             fits;
    logic [OUT_W-1:0] shreg;
    logic             last_div, last_sh;

    assign trial    = {rem, dvd[ACC_W-1]};
    assign diff     = trial - {1'b0, n_held};
    assign fits     = ~diff[CW];
    assign rem_nx   = fits ? diff[CW-1:0] : trial[CW-1:0];
    assign dvd_nx   = {dvd[ACC_W-2:0], fits};
    assign last_div = cnt == CNT_W'(ACC_W - 1);
    assign last_sh  = cnt == CNT_W'(OUT_W - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)    state_nx = ST_DIV;
            ST_DIV:   if (last_div) state_nx = ST_SHIFT;
            ST_SHIFT: if (last_sh)  state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dvd    <= '0;
            rem    <= '0;
            n_held <= '0;
            shreg  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        dvd    <= sum + ACC_W'(n_act >> 1);
                        n_held <= n_act;
                        rem    <= '0;
                    end
                end
                ST_DIV: begin
                    dvd <= dvd_nx;
                    rem <= rem_nx;
                    if (last_div) begin
                        cnt   <= '0;
                        shreg <= (n_held == '0) ? '0 : dvd_nx[OUT_W-1:0];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    shreg <= {shreg[OUT_W-2:0], 1'b0};
                    cnt   <= last_sh ? '0 : cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        ser_out      = (state == ST_SHIFT) && shreg[OUT_W-1];
        frame_strobe = (state == ST_SHIFT) && (cnt == '0);
        fsm_state    = state;
    end
endmodule

// File: rtl/tdi_serial_sum.sv
`timescale 1ns/1ps
module tdi_serial_sum
    import tdi_pkg::*;
#(
    parameter int NSTAGE = 8,
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [NSTAGE*SAMP_W-1:0] smp_data,
    input  logic                     scan_dir,
    input  logic                     cfg_par_wr,
    input  logic                     cfg_par_osr3,
    input  logic                     cfg_ser_shift,
    input  logic                     cfg_ser_bit,
    input  logic                     cfg_ser_latch,
    output logic                     ser_out,
    output logic                     frame_strobe
);
    localparam int ACC_W = SAMP_W + $clog2(NSTAGE);
    localparam int CW    = $clog2(NSTAGE + 1);

    logic              osr3;
    logic [NSTAGE-1:0] stage_mask;
    logic [CW-1:0]     n_active;
    logic              cfg_apply;
    logic              sum_done;
    logic [ACC_W-1:0]  sum_val;
    ser_state_e        fsm_state;
    logic [CW-1:0]     n_held;

    tdi_cfg_regs #(.NSTAGE(NSTAGE)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .par_wr(cfg_par_wr), .par_osr3(cfg_par_osr3),
        .ser_shift(cfg_ser_shift), .ser_bit(cfg_ser_bit), .ser_latch(cfg_ser_latch),
        .osr3(osr3), .mask(stage_mask), .n_active(n_active), .cfg_apply(cfg_apply)
    );

    tdi_accum_chain #(.NSTAGE(NSTAGE), .SAMP_W(SAMP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .valid(smp_valid), .samples(smp_data),
        .scan_dir(scan_dir), .osr3(osr3), .mask(stage_mask), .clear(cfg_apply),
        .done(sum_done), .done_sum(sum_val)
    );

    tdi_norm_ser #(.ACC_W(ACC_W), .OUT_W(SAMP_W), .CW(CW)) u_norm (
        .clk(clk), .rst_n(rst_n), .start(sum_done), .sum(sum_val), .n_act(n_active),
        .ser_out(ser_out), .frame_strobe(frame_strobe),
        .fsm_state(fsm_state), .n_held(n_held)
    );
endmodule

// File: rtl/tdi_serial_sum_chk.sv
`timescale 1ns/1ps
module tdi_serial_sum_chk
    import tdi_pkg::*;
#(
    parameter int NSTAGE = 8,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_out,
    input logic              frame_strobe,
    input logic              cfg_ser_latch,
    input logic [NSTAGE-1:0] stage_mask,
    input ser_state_e        fsm_state,
    input logic [CW-1:0]     n_held
);
    assert_single_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> (!ser_out && !frame_strobe));

    assert_zero_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SHIFT && n_held == '0) |-> !ser_out);

    assert_mask_only_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_ser_latch) |-> $stable(stage_mask));

    assert_divide_ends_in_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DIV) |=> (fsm_state != ST_IDLE));
endmodule

bind tdi_serial_sum tdi_serial_sum_chk #(.NSTAGE(NSTAGE), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .frame_strobe(frame_strobe),
    .cfg_ser_latch(cfg_ser_latch), .stage_mask(stage_mask),
    .fsm_state(fsm_state), .n_held(n_held)
);

// File: tb/test_tdi_serial_sum.sv
`timescale 1ns/1ps
module test_tdi_serial_sum;
    localparam int NST = 8;
    localparam int SW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [NST*SW-1:0] smp_data = '0;
    logic scan_dir = 1'b0;
    logic cfg_par_wr = 1'b0, cfg_par_osr3 = 1'b0;
    logic cfg_ser_shift = 1'b0, cfg_ser_bit = 1'b0, cfg_ser_latch = 1'b0;
    logic ser_out, frame_strobe;

    always #2.5 clk = ~clk;

    tdi_serial_sum i_tdi_serial_sum (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .scan_dir(scan_dir), .cfg_par_wr(cfg_par_wr), .cfg_par_osr3(cfg_par_osr3),
        .cfg_ser_shift(cfg_ser_shift), .cfg_ser_bit(cfg_ser_bit),
        .cfg_ser_latch(cfg_ser_latch), .ser_out(ser_out), .frame_strobe(frame_strobe)
    );

    // reference state
    logic [SW-1:0] hist [0:1023][0:NST-1];
    int nhist = 0;
    int m_osr = 2;
    bit m_dir = 0;
    logic [NST-1:0] m_mask = '1;
    int vcount = 0;
    int full_scale = 0;
    bit exp_ser [0:32767];
    bit exp_frm [0:32767];
    logic [15:0] wq[$];
    string tq[$];
    string cur_tag = "R1";
    int ecount = 0;
    int vectors = 0;
    int miss = 0;
    bit collecting = 0;
    int nbits = 0;
    logic [15:0] cw = '0;

    always @(posedge clk) ecount <= ecount + 1;

    always @(negedge clk) begin
        vectors++;
        if (ser_out !== exp_ser[ecount] || frame_strobe !== exp_frm[ecount]) begin
            miss++;
            $display("FAIL %s cycle %0d: ser/frame actual %b%b expected %b%b",
                     cur_tag, ecount, ser_out, frame_strobe, exp_ser[ecount], exp_frm[ecount]);
        end
        if (frame_strobe) begin
            collecting = 1;
            nbits = 0;
        end
        if (collecting) begin
            cw = {cw[14:0], ser_out};
            nbits++;
            if (nbits == 16) begin
                collecting = 0;
                vectors++;
                if (wq.size() == 0) begin
                    miss++;
                    $display("FAIL R8 unexpected word actual %h expected none", cw);
                end else begin
                    logic [15:0] ew;
                    string et;
                    ew = wq.pop_front();
                    et = tq.pop_front();
                    if (cw !== ew) begin
                        miss++;
                        $display("FAIL %s word actual %h expected %h", et, cw, ew);
                    end
                end
            end
        end
    end

    task automatic send_one(input string tag);
        logic [NST*SW-1:0] v;
        int d, n0, n;
        longint sum;
        logic [15:0] w;
        for (int s = 0; s < NST; s++) begin
            logic [SW-1:0] val;
            val = full_scale ? 16'hFFFF
                             : 16'(((vcount * 40503) + (s * 9973) + 12345) ^ (vcount << 5));
            v[s*SW +: SW] = val;
            hist[nhist][s] = val;
        end
        vcount++;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v;
        @(posedge clk);
        #1;
        n0 = ecount;
        d = 7 * m_osr;
        if (nhist >= d) begin
            sum = 0;
            for (int k = 0; k < NST; k++) begin
                int ph;
                ph = m_dir ? (NST - 1 - k) : k;
                if (m_mask[ph]) sum += hist[nhist - (d - k * m_osr)][ph];
            end
            n = $countones(m_mask);
            w = (n == 0) ? 16'h0 : 16'((sum + n / 2) / n);
            exp_frm[n0 + 19] = 1'b1;
            for (int i = 0; i < 16; i++) exp_ser[n0 + 19 + i] = w[15 - i];
            wq.push_back(w);
            tq.push_back(tag);
        end
        nhist++;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (38) @(negedge clk);
    endtask

    task automatic run(input int cnt, input string tag);
        cur_tag = tag;
        for (int i = 0; i < cnt; i++) send_one(tag);
    endtask

    task automatic par_cfg(input bit o3);
        @(negedge clk);
        cfg_par_wr = 1'b1;
        cfg_par_osr3 = o3;
        @(negedge clk);
        cfg_par_wr = 1'b0;
        m_osr = o3 ? 3 : 2;
        nhist = 0;
    endtask

    // R10: first bit ratio select, then mask[7] .. mask[0]
    task automatic ser_cfg(input bit o3, input logic [NST-1:0] mk);
        logic [NST:0] bits;
        bits = {o3, mk};
        for (int i = NST; i >= 0; i--) begin
            @(negedge clk);
            cfg_ser_shift = 1'b1;
            cfg_ser_bit = bits[i];
        end
        @(negedge clk);
        cfg_ser_shift = 1'b0;
        cfg_ser_latch = 1'b1;
        @(negedge clk);
        cfg_ser_latch = 1'b0;
        m_osr = o3 ? 3 : 2;
        m_mask = mk;
        nhist = 0;
    endtask

    task automatic set_dir(input bit dv);
        @(negedge clk);
        scan_dir = dv;
        m_dir = dv;
        nhist = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog expired: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        cur_tag = "R1 reset outputs";
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 defaults (ratio 2, all stages), R2 forward alignment, R9 warm-up, R8 framing
        run(20, "R2 R9 forward ratio2 defaults R1");
        full_scale = 1;
        run(17, "R6 full-scale no overflow");
        full_scale = 0;
        par_cfg(1'b1);
        run(26, "R3 ratio3 parallel load R9");
        set_dir(1'b1);
        run(26, "R4 reverse scan ratio3");
        ser_cfg(1'b0, 8'b1011_0010);
        run(19, "R5 R10 serial mask N=4 rounding R6");
        par_cfg(1'b0);
        run(18, "R5 parallel write keeps mask");
        ser_cfg(1'b1, 8'b0101_1000);
        run(24, "R6 rounding N=3 ratio3 R10");
        set_dir(1'b0);
        ser_cfg(1'b0, 8'b0000_0001);
        run(18, "R6 single stage N=1");
        ser_cfg(1'b0, 8'b0000_0000);
        run(18, "R7 no stage enabled");
        cur_tag = "R8 tail quiet";
        repeat (60) @(negedge clk);
        vectors++;
        if (wq.size() != 0) begin
            miss++;
            $display("FAIL R8 words missing actual %0d expected 0", wq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule